// File: doc/BRIEF.md
# Bus Cycle Ready and Reset Synchronizer

This block tells a processor when to finish its current bus cycle. It drives an active-low ready output. Two pairs of inputs can end a cycle. The first pair is an asynchronous ready level with its own enable, and it is passed through a multi-flop synchronizer before use. The second pair is a synchronous ready level with its own enable, and it is sampled directly on the clock edge. Each pair ends the cycle only when both of its lines are low.

The two bus status lines mark the start of each cycle. A start arms the block for exactly one ready pulse. After the pulse, the block ignores further ready requests until the next cycle starts.

The block also turns an asynchronous active-low reset request into an active-high reset output that is aligned to the clock. While the reset output is high, ready is held low.

Top module: `bus_ready_sync`

## Requirements
- R1: `reset_o` takes the inverse of `res_n` exactly SYNC_STAGES rising edges (default 2) after `res_n` changes, and it is high from power-up.
- R2: While `reset_o` is high, `ready_n` is low.
- R3: A status value other than idle (`stat_n` = 2'b11) sampled on an edge starts a bus cycle. `ready_n` is high after that edge, even if a ready pair is asserted.
- R4: In an armed cycle with idle status, `sync_rdy_n` and `sync_en_n` both low on an edge drive `ready_n` low right after that edge.
- R5: In an armed cycle, `async_rdy_n` and `async_en_n` both low drive `ready_n` low SYNC_STAGES+1 edges after they are applied, if the synchronous pair has not already fired.
- R6: `ready_n` is low for exactly one cycle per bus cycle. It then stays high until the next start, even if a ready pair stays asserted.
- R7: A pair with only its ready line low, or only its enable line low, never drives `ready_n` low.
- R8: After reset is released, `ready_n` stays high until a bus cycle has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| res_n | input | 1 | Asynchronous reset request, active low |
| async_rdy_n | input | 1 | Asynchronous ready, active low |
| async_en_n | input | 1 | Enable for the asynchronous ready, active low |
| sync_rdy_n | input | 1 | Synchronous ready, active low |
| sync_en_n | input | 1 | Enable for the synchronous ready, active low |
| stat_n | input | 2 | Bus status (bit 1 and bit 0); 2'b11 means idle |
| ready_n | output | 1 | Cycle-complete indication to the processor, active low |
| reset_o | output | 1 | Synchronized system reset, active high |

## Verification
The assertions check several rules on every cycle:
- Ready is held low whenever reset is high.
- A start clears ready.
- An armed cycle that sees the synchronous pair asserted produces ready on the next cycle.
- An unarmed block never raises ready.
- Ready never stays low for two cycles in a row outside reset.
- The reset output follows the request with the exact synchronizer delay.

Only the bench's scenarios show the full latency of the asynchronous path. They also show the interaction of both pairs across all sixteen input combinations, and that a half-asserted pair has no effect.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam logic [1:0] STAT_IDLE = 2'b11;

  function automatic logic cycle_start(input logic [1:0] stat_n);
    return stat_n != STAT_IDLE;
  endfunction

  function automatic logic pair_fires(input logic rdy_n, input logic en_n);
    return !rdy_n && !en_n;
  endfunction
endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int          WIDTH  = 1,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain = {STAGES{INIT}};

  always_ff @(posedge clk) chain[0] <= d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) chain[i] <= chain[i-1];
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/brs_reset_gen.sv
module brs_reset_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic res_n,
  output logic rst_next,
  output logic reset_o
);
  localparam int PRE_STAGES = SYNC_STAGES - 1;

  logic req;
  logic rst_q = 1'b1;
  logic [1:0] age_q = 2'd0;

  assign req = !res_n;

  generate
    if (PRE_STAGES > 0) begin : g_pre
      brs_sync #(.WIDTH(1), .STAGES(PRE_STAGES), .INIT(1'b1)) u_pre (
        .clk (clk),
        .d   (req),
        .q   (rst_next)
      );
    end else begin : g_direct
      assign rst_next = req;
    end
  endgenerate

  always_ff @(posedge clk) begin
    rst_q <= rst_next;
    if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign reset_o = rst_q;

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      AST_RESET_LATENCY: assert property (@(posedge clk) disable iff (age_q != 2'd2)
        reset_o == $past(req, 2)); // R1
    end
  endgenerate
endmodule

// File: rtl/brs_ready_ctrl.sv
module brs_ready_ctrl
  import brs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_next,
  input  logic       rst_now,
  input  logic [1:0] stat_n,
  input  logic       sync_rdy_n,
  input  logic       sync_en_n,
  input  logic       arn_s,
  input  logic       aen_s,
  output logic       ready_n
);
  logic ready_q = 1'b0;
  logic armed_q = 1'b0;
  logic fire;

  assign fire = pair_fires(sync_rdy_n, sync_en_n) || pair_fires(arn_s, aen_s);

  always_ff @(posedge clk) begin
    if (rst_next) begin
      ready_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (cycle_start(stat_n)) begin
      ready_q <= 1'b1;
      armed_q <= 1'b1;
    end else if (armed_q && fire) begin
      ready_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
    end
  end

  assign ready_n = ready_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst_now)
    (cycle_start(stat_n) && !rst_next) |=> ready_n); // R3
  AST_SYNC_FIRE: assert property (@(posedge clk) disable iff (rst_now)
    (armed_q && !sync_rdy_n && !sync_en_n && stat_n == STAT_IDLE && !rst_next) |=> !ready_n); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst_now)
    !ready_n |=> ready_n); // R6
  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (rst_now)
    (!armed_q && stat_n == STAT_IDLE && !rst_next) |=> ready_n); // R8
endmodule

// File: rtl/bus_ready_sync.sv
module bus_ready_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       res_n,
  input  logic       async_rdy_n,
  input  logic       async_en_n,
  input  logic       sync_rdy_n,
  input  logic       sync_en_n,
  input  logic [1:0] stat_n,
  output logic       ready_n,
  output logic       reset_o
);
  logic [1:0] async_s;
  logic       rst_next;

  brs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_async_sync (
    .clk (clk),
    .d   ({async_en_n, async_rdy_n}),
    .q   (async_s)
  );

  brs_reset_gen #(.SYNC_STAGES(SYNC_STAGES)) u_reset (
    .clk      (clk),
    .res_n    (res_n),
    .rst_next (rst_next),
    .reset_o  (reset_o)
  );

  brs_ready_ctrl u_ready (
    .clk        (clk),
    .rst_next   (rst_next),
    .rst_now    (reset_o),
    .stat_n     (stat_n),
    .sync_rdy_n (sync_rdy_n),
    .sync_en_n  (sync_en_n),
    .arn_s      (async_s[0]),
    .aen_s      (async_s[1]),
    .ready_n    (ready_n)
  );

  AST_RESET_HOLDS_READY: assert property (@(posedge clk) reset_o |-> !ready_n); // R2
endmodule

// File: tb/bus_ready_sync_tb.sv
`timescale 1ns/1ps
module bus_ready_sync_tb;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic res_n, a_rdy, a_en, s_rdy, s_en;
  logic [1:0] stat;
  logic ready_n, reset_o;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bus_ready_sync #(.SYNC_STAGES(STAGES)) u_dut (
    .clk(clk), .res_n(res_n), .async_rdy_n(a_rdy), .async_en_n(a_en),
    .sync_rdy_n(s_rdy), .sync_en_n(s_en), .stat_n(stat),
    .ready_n(ready_n), .reset_o(reset_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    a_rdy = 1; a_en = 1; s_rdy = 1; s_en = 1; stat = 2'b11;
  endtask

  initial begin
    res_n = 0;
    quiet();
    step();
    check("R1 reset at power-up", reset_o, 1'b1);
    check("R2 ready held in reset", ready_n, 1'b0);
    step();
    res_n = 1;
    s_rdy = 0; s_en = 0;
    step();
    check("R1 reset still high one edge after release", reset_o, 1'b1);
    step();
    check("R1 reset low two edges after release", reset_o, 1'b0);
    check("R8 ready high after release", ready_n, 1'b1);
    step(); step();
    check("R8 no ready before a cycle starts", ready_n, 1'b1);
    quiet();
    step(); step(); step();

    for (int combo = 0; combo < 16; combo++) begin
      logic sf, af;
      int first;
      quiet();
      step(); step(); step();
      stat = 2'b01;
      step();
      check("R3 start clears ready", ready_n, 1'b1);
      stat = 2'b11;
      s_rdy = combo[0]; s_en = combo[1]; a_rdy = combo[2]; a_en = combo[3];
      sf = !s_rdy && !s_en;
      af = !a_rdy && !a_en;
      first = sf ? 1 : (af ? STAGES + 1 : 0);
      for (int k = 1; k <= 6; k++) begin
        step();
        if (k == first)
          check(sf ? "R4 sync ready" : "R5 async ready", ready_n, 1'b0);
        else if (first != 0 && k > first)
          check("R6 single pulse per cycle", ready_n, 1'b1);
        else if (first == 0)
          check("R7 half-asserted pair ignored", ready_n, 1'b1);
        else
          check("R5 ready not before latency", ready_n, 1'b1);
      end
    end

    quiet();
    s_rdy = 0; s_en = 0;
    stat = 2'b10;
    step();
    check("R3 start wins over asserted pair", ready_n, 1'b1);
    stat = 2'b11;
    step();
    check("R4 ready after start with pair held", ready_n, 1'b0);
    step();
    check("R6 released after pulse", ready_n, 1'b1);

    quiet();
    stat = 2'b00;
    step();
    stat = 2'b11;
    res_n = 0;
    step();
    check("R1 reset not yet high", reset_o, 1'b0);
    step();
    check("R1 reset high after two edges", reset_o, 1'b1);
    s_rdy = 0; s_en = 0;
    step();
    check("R2 ready held low in reset", ready_n, 1'b0);
    step();
    check("R2 ready held low in reset", ready_n, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule